// File: doc/BRIEF.md
# Block-Transfer DMA Channel

This block is one DMA channel that moves data in blocks. Software programs the channel through a small register bus. It sets a source address, a destination address, a block length in units, a block count, the unit width, how each address steps, and which side is the block area. It also picks one of sixteen request lines as the trigger. Each accepted request moves one whole block as an unbroken burst. Every unit takes a read cycle on the memory port followed by a write cycle.

After each block, the block-area address goes back to where that block started, while the other address keeps advancing. This lets a fixed buffer be swept repeatedly into or out of a larger region. The channel stops by itself when the block count runs out, and it can raise an end interrupt. A request that arrives while a block is running is remembered once and served after that block.

Top module: `blkdma_chan`

## Requirements
- R1: After reset, every register reads zero, `mem_rd`, `mem_wr`, `act_clr`, `cpu_req` and `end_irq` are low.
- R2: A block starts only while both run bits (CTRL bit 0 = transfer enable, CTRL bit 1 = master enable) are 1 and the count register (offset 4) is nonzero. A request at any other time is ignored: no memory access, addresses unchanged.
- R3: Only the request line chosen by MODE bits 10:7 can start a block. Pulses on other lines have no effect.
- R4: Each unit is one cycle with `mem_rd` high at the source address, then one cycle with `mem_wr` high at the destination address carrying the data read. A block of N units gives exactly N writes.
- R5: MODE bits 1:0 (source) and 3:0's upper pair, bits 3:2 (destination), pick the step: 01 add, 10 subtract, 00/11 hold. The step is the unit size in bytes, where MODE bits 5:4 give 00 = 1, 01 = 2, otherwise 4.
- R6: MODE bit 6 selects the block area (0 = source, 1 = destination). That address returns to its block-start value after each block, and the other address keeps its stepped value.
- R7: Each finished block decrements the count. When the count reaches zero, transfer enable clears, and `end_irq` rises if MODE bit 11 is 1. Any write to CTRL (offset 6) lowers `end_irq`.
- R8: Requests seen on the selected line during a block collapse into one pending flag, which starts exactly one further block afterwards.
- R9: Block length comes from two byte registers (offset 2 high, offset 3 low). A length of 0 means 65536 units.
- R10: When a block is accepted, MODE bit 12 = 1 pulses `act_clr` for one cycle on the selected line only. With MODE bit 12 = 0, `cpu_req` pulses instead. The two never pulse together.

Register offsets: 0 source address, 1 destination address, 2/3 length bytes, 4 count, 5 MODE, 6 CTRL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_in | input | 16 | Activation request lines |
| act_clr | output | 16 | One-cycle clear pulse to the accepted request source |
| cpu_req | output | 1 | One-cycle pulse forwarding an accepted request to the CPU |
| end_irq | output | 1 | Transfer-end interrupt |
| mem_rd | output | 1 | Memory read cycle |
| mem_wr | output | 1 | Memory write cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_size | output | 2 | Unit width code of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid in the read cycle |

## Verification
The assertions check, on every cycle, the read-then-write pairing of units and that written data equals the word just read. They also check that a burst starts only with both run bits set, that the clear and forward pulses are exclusive and one-hot, and that the end interrupt and the drop of transfer enable appear only at the end of the last block. The scenarios alone show the final address values for each step mode and block side, the bytes landing in memory, the collapsing of several requests into one extra block, the request-line selection, and the 65536-unit reading of a zero length.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    localparam int REG_W   = 32;
    localparam int LEN_W   = 16;
    localparam int REQ_N   = 16;
    localparam int SEL_W   = $clog2(REQ_N);
    localparam int UNITS_W = LEN_W + 1;

    localparam logic [2:0] OFS_SRC  = 3'd0;
    localparam logic [2:0] OFS_DST  = 3'd1;
    localparam logic [2:0] OFS_LENH = 3'd2;
    localparam logic [2:0] OFS_LENL = 3'd3;
    localparam logic [2:0] OFS_CNT  = 3'd4;
    localparam logic [2:0] OFS_MODE = 3'd5;
    localparam logic [2:0] OFS_CTRL = 3'd6;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_INC   = 2'b01,
        STEP_DEC   = 2'b10,
        STEP_HOLD2 = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        UNIT_BYTE  = 2'b00,
        UNIT_HALF  = 2'b01,
        UNIT_FULL  = 2'b10,
        UNIT_FULL2 = 2'b11
    } unit_e;

    typedef struct packed {
        logic             req_clr;
        logic             end_ie;
        logic [SEL_W-1:0] sel;
        logic             blk_dst;
        unit_e            unit;
        step_e            dstep;
        step_e            sstep;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } st_e;

    function automatic logic [2:0] unit_bytes(unit_e u);
        case (u)
            UNIT_BYTE: return 3'd1;
            UNIT_HALF: return 3'd2;
            default:   return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/blkdma_step.sv
module blkdma_step
    import blkdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  step_e         mode,
    input  unit_e         unit,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] delta;

    always_comb begin
        delta = AW'(unit_bytes(unit));
        case (mode)
            STEP_INC: nxt = cur + delta;
            STEP_DEC: nxt = cur - delta;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             upd,
    input  logic [AW-1:0]    src_n,
    input  logic [AW-1:0]    dst_n,
    input  logic             blk_done,
    input  logic             fin,
    output logic [AW-1:0]    src_q,
    output logic [AW-1:0]    dst_q,
    output logic [LEN_W-1:0] len_q,
    output logic [CW-1:0]    cnt_q,
    output mode_t            mode_q,
    output logic             te_q,
    output logic             me_q,
    output logic             irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
            te_q   <= 1'b0;
            me_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    OFS_SRC:  src_q  <= reg_wdata[AW-1:0];
                    OFS_DST:  dst_q  <= reg_wdata[AW-1:0];
                    OFS_LENH: len_q[15:8] <= reg_wdata[7:0];
                    OFS_LENL: len_q[7:0]  <= reg_wdata[7:0];
                    OFS_CNT:  cnt_q  <= reg_wdata[CW-1:0];
                    OFS_MODE: mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
                    OFS_CTRL: begin
                        te_q  <= reg_wdata[0];
                        me_q  <= reg_wdata[1];
                        irq_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (upd) begin
                src_q <= src_n;
                dst_q <= dst_n;
            end
            if (blk_done) cnt_q <= cnt_q - 1'b1;
            if (fin) begin
                te_q <= 1'b0;
                if (mode_q.end_ie) irq_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_SRC:  reg_rdata = REG_W'(src_q);
            OFS_DST:  reg_rdata = REG_W'(dst_q);
            OFS_LENH: reg_rdata = REG_W'(len_q[15:8]);
            OFS_LENL: reg_rdata = REG_W'(len_q[7:0]);
            OFS_CNT:  reg_rdata = REG_W'(cnt_q);
            OFS_MODE: reg_rdata = REG_W'(mode_q);
            OFS_CTRL: reg_rdata = REG_W'({me_q, te_q});
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
    import blkdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REQ_N-1:0] req_in,
    input  mode_t            mode_q,
    input  logic [LEN_W-1:0] len_q,
    input  logic [CW-1:0]    cnt_q,
    input  logic             te_q,
    input  logic             me_q,
    input  logic [AW-1:0]    src_q,
    input  logic [AW-1:0]    dst_q,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_size,
    output logic [DW-1:0]    mem_wdata,
    output logic             upd,
    output logic [AW-1:0]    src_n,
    output logic [AW-1:0]    dst_n,
    output logic             blk_done,
    output logic             fin,
    output logic [REQ_N-1:0] act_clr,
    output logic             cpu_req
);
    st_e                st;
    logic [UNITS_W-1:0] units;
    logic               pend;
    logic [DW-1:0]      dbuf;
    logic [AW-1:0]      anchor;
    logic [AW-1:0]      src_step, dst_step;
    logic               hit, go, last;

    blkdma_step #(.AW(AW)) u_src_step (
        .cur(src_q), .mode(mode_q.sstep), .unit(mode_q.unit), .nxt(src_step)
    );
    blkdma_step #(.AW(AW)) u_dst_step (
        .cur(dst_q), .mode(mode_q.dstep), .unit(mode_q.unit), .nxt(dst_step)
    );

    assign hit  = req_in[mode_q.sel];
    assign go   = (st == ST_IDLE) && te_q && me_q && (cnt_q != '0) && (hit || pend);
    assign last = (units == UNITS_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            units  <= '0;
            pend   <= 1'b0;
            dbuf   <= '0;
            anchor <= '0;
        end else begin
            if (st != ST_IDLE && hit) pend <= 1'b1;
            case (st)
                ST_IDLE: if (go) begin
                    st     <= ST_RD;
                    units  <= (len_q == '0) ? (UNITS_W'(1) << LEN_W) : UNITS_W'(len_q);
                    anchor <= mode_q.blk_dst ? dst_q : src_q;
                    pend   <= 1'b0;
                end
                ST_RD: begin
                    dbuf <= mem_rdata;
                    st   <= ST_WR;
                end
                ST_WR: begin
                    units <= units - 1'b1;
                    st    <= last ? ST_IDLE : ST_RD;
                end
                default: st <= ST_IDLE;
            endcase
            if (fin) pend <= 1'b0;
        end
    end

    always_comb begin
        mem_rd    = (st == ST_RD);
        mem_wr    = (st == ST_WR);
        mem_addr  = mem_rd ? src_q : dst_q;
        mem_size  = mode_q.unit;
        mem_wdata = dbuf;
        upd       = mem_wr;
        blk_done  = mem_wr && last;
        fin       = blk_done && (cnt_q == CW'(1));
        src_n     = (blk_done && !mode_q.blk_dst) ? anchor : src_step;
        dst_n     = (blk_done &&  mode_q.blk_dst) ? anchor : dst_step;
        act_clr   = (go && mode_q.req_clr) ? (REQ_N'(1) << mode_q.sel) : '0;
        cpu_req   = go && !mode_q.req_clr;
    end
endmodule

// File: rtl/blkdma_chan.sv
module blkdma_chan
    import blkdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [15:0]       req_in,
    output logic [15:0]       act_clr,
    output logic              cpu_req,
    output logic              end_irq,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [ADDR_W-1:0] src_q, dst_q, src_n, dst_n;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  cnt_q;
    mode_t             mode_q;
    logic              te_q, me_q, irq_q;
    logic              upd, blk_done, fin;

    blkdma_regs #(.AW(ADDR_W), .CW(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .upd(upd), .src_n(src_n), .dst_n(dst_n), .blk_done(blk_done), .fin(fin),
        .src_q(src_q), .dst_q(dst_q), .len_q(len_q), .cnt_q(cnt_q), .mode_q(mode_q),
        .te_q(te_q), .me_q(me_q), .irq_q(irq_q)
    );

    blkdma_engine #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W)) u_eng (
        .clk(clk), .rst(rst), .req_in(req_in),
        .mode_q(mode_q), .len_q(len_q), .cnt_q(cnt_q), .te_q(te_q), .me_q(me_q),
        .src_q(src_q), .dst_q(dst_q), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .upd(upd), .src_n(src_n), .dst_n(dst_n),
        .blk_done(blk_done), .fin(fin), .act_clr(act_clr), .cpu_req(cpu_req)
    );

    assign end_irq = irq_q;
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [15:0]       act_clr,
    input logic              cpu_req,
    input logic              te_q,
    input logic              me_q,
    input logic              irq_q
);
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R4
    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr); // R4
    AST_WDATA_IS_READ: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_wdata == $past(mem_rdata)); // R4
    AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !$past(mem_wr)) |-> $past(te_q && me_q)); // R2
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_clr)); // R10
    AST_CLR_OR_FORWARD: assert property (@(posedge clk) disable iff (rst)
        !((|act_clr) && cpu_req)); // R10
    AST_IRQ_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !$past(irq_q)) |-> !te_q); // R7
    AST_TE_DROP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($fell(te_q) && !$past(reg_we)) |-> $past(mem_wr)); // R7
endmodule

bind blkdma_chan blkdma_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .act_clr(act_clr), .cpu_req(cpu_req),
    .te_q(te_q), .me_q(me_q), .irq_q(irq_q)
);

// File: tb/blkdma_chan_tb.sv
module blkdma_chan_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] req_in = '0;
    logic [15:0] act_clr;
    logic        cpu_req, end_irq, mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;

    int checks = 0;
    int fails  = 0;
    int n_wr = 0, n_clr3 = 0, n_clr_any = 0, n_fwd = 0, n_rd = 0;
    int cyc = 0;

    logic [7:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    blkdma_chan u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_in(req_in), .act_clr(act_clr), .cpu_req(cpu_req),
        .end_irq(end_irq), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always_comb begin
        mem_rdata = {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                     mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) n_rd <= n_rd + 1;
        if (act_clr[3]) n_clr3 <= n_clr3 + 1;
        if (|act_clr) n_clr_any <= n_clr_any + 1;
        if (cpu_req) n_fwd <= n_fwd + 1;
        if (mem_wr) begin
            n_wr <= n_wr + 1;
            mem[mem_addr[7:0]] <= mem_wdata[7:0];
            if (mem_size != 2'b00) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
            if (mem_size[1]) begin
                mem[8'(mem_addr[7:0] + 8'd2)] <= mem_wdata[23:16];
                mem[8'(mem_addr[7:0] + 8'd3)] <= mem_wdata[31:24];
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 195000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: act=%0d exp<=195000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(int line, int width);
        @(negedge clk);
        req_in[line] = 1'b1;
        idle(width);
        req_in[line] = 1'b0;
    endtask

    task automatic prog(logic [31:0] s, logic [31:0] d, logic [15:0] len, logic [15:0] cnt,
                        logic [12:0] mode);
        wr(3'd6, 32'd0);
        wr(3'd0, s);
        wr(3'd1, d);
        wr(3'd2, {24'd0, len[15:8]});
        wr(3'd3, {24'd0, len[7:0]});
        wr(3'd4, {16'd0, cnt});
        wr(3'd5, {19'd0, mode});
    endtask

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] len;
        logic [15:0] cnt;
        logic [12:0] mode;
        logic [31:0] exp_src;
        logic [31:0] exp_dst;
    } vec_t;

    // mode = {req_clr, end_ie, sel[3:0], blk_dst, unit[1:0], dstep[1:0], sstep[1:0]}, sel = 3
    localparam vec_t VECS [6] = '{
        '{32'h10, 32'h80, 16'd4, 16'd2, 13'h1985, 32'h10, 32'h88},
        '{32'h20, 32'hC0, 16'd3, 16'd2, 13'h19D9, 32'h2C, 32'hC0},
        '{32'h40, 32'hE0, 16'd2, 16'd3, 13'h19A2, 32'h40, 32'hE0},
        '{32'h30, 32'h90, 16'd5, 16'd1, 13'h19C4, 32'h30, 32'h90},
        '{32'h00, 32'hA0, 16'd1, 16'd4, 13'h19E5, 32'h10, 32'hA0},
        '{32'h50, 32'h60, 16'd2, 16'd2, 13'h1996, 32'h50, 32'h68}
    };

    initial begin
        logic [31:0] v;
        int b0, c0, f0, r0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        rd(3'd6, v); check("R1 ctrl", v, 0);
        rd(3'd0, v); check("R1 src", v, 0);
        rd(3'd5, v); check("R1 mode", v, 0);
        check("R1 outputs", {28'd0, mem_rd, mem_wr, end_irq, cpu_req}, 0);

        // Table: R4 R5 R6 R7
        for (int k = 0; k < 6; k++) begin
            prog(VECS[k].src, VECS[k].dst, VECS[k].len, VECS[k].cnt, VECS[k].mode);
            wr(3'd6, 32'd3);
            for (int b = 0; b < int'(VECS[k].cnt); b++) begin
                pulse(3, 1);
                idle(2 * int'(VECS[k].len) + 3);
            end
            rd(3'd0, v); check("R5/R6 src final", v, VECS[k].exp_src);
            rd(3'd1, v); check("R5/R6 dst final", v, VECS[k].exp_dst);
            rd(3'd6, v); check("R7 te cleared", v, 32'd2);
            check("R7 end_irq set", {31'd0, end_irq}, 1);
        end

        // R7 write to CTRL lowers irq
        wr(3'd6, 32'd0);
        idle(1);
        check("R7 irq cleared by ctrl write", {31'd0, end_irq}, 0);

        // R4/R5/R6 memory contents
        check("R4 block copy first", {24'd0, mem[8'h80]}, {24'd0, 8'h10 ^ 8'h5A});
        check("R6 block repeats", {24'd0, mem[8'h84]}, {24'd0, 8'h10 ^ 8'h5A});
        check("R4 block copy last", {24'd0, mem[8'h87]}, {24'd0, 8'h13 ^ 8'h5A});
        check("R5 fixed source", {24'd0, mem[8'h94]}, {24'd0, 8'h30 ^ 8'h5A});
        check("R5 half unit down", {24'd0, mem[8'hBD]}, {24'd0, 8'h2B ^ 8'h5A});
        check("R5 full unit", {24'd0, mem[8'hA3]}, {24'd0, 8'h0F ^ 8'h5A});
        check("R5 full unit down", {24'd0, mem[8'hE0]}, {24'd0, 8'h3C ^ 8'h5A});

        // R2 gating by the two run bits and a zero count
        prog(32'h10, 32'h70, 16'd1, 16'd1, 13'h1985);
        wr(3'd6, 32'd1);
        b0 = n_rd; pulse(3, 1); idle(8);
        check("R2 te only: no access", n_rd - b0, 0);
        wr(3'd6, 32'd2);
        b0 = n_rd; pulse(3, 1); idle(8);
        check("R2 me only: no access", n_rd - b0, 0);
        rd(3'd0, v); check("R2 src unchanged", v, 32'h10);
        wr(3'd4, 32'd0);
        wr(3'd6, 32'd3);
        b0 = n_rd; pulse(3, 1); idle(8);
        check("R2 zero count: no access", n_rd - b0, 0);

        // R3 line select
        wr(3'd4, 32'd1);
        wr(3'd6, 32'd3);
        b0 = n_wr; pulse(5, 1); idle(8);
        check("R3 other line ignored", n_wr - b0, 0);
        b0 = n_wr; pulse(3, 1); idle(8);
        check("R3/R4 selected line one write", n_wr - b0, 1);

        // R8 pending collapse, R10 clear pulse
        prog(32'h10, 32'h70, 16'd4, 16'd5, 13'h1985);
        wr(3'd6, 32'd3);
        b0 = n_wr; c0 = n_clr3; f0 = n_fwd;
        pulse(3, 4);
        idle(30);
        rd(3'd4, v); check("R8 two blocks run", v, 32'd3);
        check("R8 writes for two blocks", n_wr - b0, 8);
        check("R10 clear pulses", n_clr3 - c0, 2);
        check("R10 no forward when clearing", n_fwd - f0, 0);

        // R10 forward instead of clear; R7 no irq when disabled
        prog(32'h10, 32'h70, 16'd1, 16'd1, 13'h0185);
        wr(3'd6, 32'd3);
        c0 = n_clr_any; f0 = n_fwd;
        pulse(3, 1); idle(8);
        check("R10 forward pulse", n_fwd - f0, 1);
        check("R10 no clear pulse", n_clr_any - c0, 0);
        rd(3'd6, v); check("R7 te cleared, irq off", v, 32'd2);
        check("R7 irq stays low when disabled", {31'd0, end_irq}, 0);

        // R9 zero length means 65536 units
        prog(32'h20, 32'h70, 16'd0, 16'd1, 13'h1981);
        rd(3'd2, v); check("R9 length high byte", v, 0);
        wr(3'd6, 32'd3);
        r0 = n_rd;
        pulse(3, 1);
        idle(2 * 65535);
        rd(3'd6, v); check("R9 still running", v, 32'd3);
        idle(10);
        rd(3'd6, v); check("R9 finished", v, 32'd2);
        check("R9 unit count", n_rd - r0, 65536);
        rd(3'd0, v); check("R6 block side restored", v, 32'h20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule